// File: doc/BRIEF.md
# Peripheral Request Channel Router

This block sits between a set of peripheral DMA request lines and the physical channels of a DMA engine. Every request line owns one programmable map entry. The entry holds an enable flag and a 5-bit channel number. A channel's request input is driven by every request line whose enabled entry names that channel. When a channel acknowledges, the acknowledge goes back to each request line that is currently mapped onto it.

The map table is reached through a simple register port. The port has a write side and a read side, each with its own address, so both can act in the same cycle. Entries for lines 0 to 63 sit in a low window. Lines 64 and up sit in a high window, addressed by the low six bits of the line number. Software is expected to program an entry before it starts the channel that serves it. Writing zero to an entry detaches the line. Channel arbitration and data movement belong to other blocks.

Top module: `req_router`

## Requirements
- R1: While `rstN` is low, all map entries clear to zero and `rdData` clears to zero. As a result, after reset no `chanReq` or `perAck` bit is asserted, whatever `perReq` and `chanAck` hold.
- R2: A write to an entry stores `wrData[7]` as the enable flag and `wrData[4:0]` as the channel number. A read returns the stored enable flag at bit 7 and the channel number at bits 4:0, with every other bit zero. `rdData` is registered: it updates at the clock edge that samples `rdEn` and holds its value while `rdEn` is low.
- R3: Line n < 64 is addressed at byte address 0x100 + 4·n. Line n >= 64 is addressed at 0x1100 + 4·(n mod 64).
- R4: `chanReq[c]` is the OR of `perReq[n]` over all lines n whose entry is enabled and names channel c.
- R5: An entry with its enable flag clear contributes to no channel request and receives no acknowledge, whatever its channel field holds.
- R6: Writing zero to an entry removes the mapping, so that line reaches no channel afterwards.
- R7: `perAck[n]` equals `chanAck[c]` when line n's entry is enabled and names channel c. Otherwise `perAck[n]` is 0.
- R8: The following accesses hit no entry: a misaligned address (bits 1:0 not zero), an address outside both windows, or an address that decodes to a line at or above NUM_LINES. A write to such an address changes no entry, and a read from it returns zero.
- R9: A write changes reads and routing from the cycle after its clock edge. In the cycle of the write, `chanReq` and `perAck` still follow the old entry. A read of the same entry in that same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Map write strobe |
| wrAddr | input | ADDR_W | Byte address of the entry to write |
| wrData | input | DATA_W | Write data (bit 7 enable, bits 4:0 channel) |
| rdEn | input | 1 | Map read strobe |
| rdAddr | input | ADDR_W | Byte address of the entry to read |
| rdData | output | DATA_W | Registered read data |
| perReq | input | NUM_LINES | Peripheral request lines |
| chanReq | output | NUM_CHANS | Combined request per physical channel |
| chanAck | input | NUM_CHANS | Acknowledge from each physical channel |
| perAck | output | NUM_LINES | Acknowledge returned to each request line |

## Verification
Two functions can fall in the same cycle: a table write, and the use of that same entry by routing and by a read. The bench provokes this on purpose. It writes an entry while reading the same entry through the read side. It also rewrites an entry while its request line is held high. For each case it judges the combined channel request before the edge against the old mapping, and after the edge against the new one. It expects the old value back from the colliding read. Random traffic mixes writes, reads and full-width request and acknowledge patterns on the same cycles, and compares them against a bench model of the table.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;

  // Field layout of one map entry as seen on the register port.
  localparam int ENABLE_BIT   = 7;
  localparam int CHAN_FIELD_W = 5;
  localparam int MAX_CHANS    = 1 << CHAN_FIELD_W;

  // Two address windows of 64 entries each give at most 128 lines.
  localparam int WINDOW_LINES = 64;
  localparam int LINE_IDX_W   = 7;
  localparam int MAX_LINES    = 2 * WINDOW_LINES;

  // Upper address byte selecting each window.
  localparam logic [7:0] LOW_WINDOW_PAGE  = 8'h01;
  localparam logic [7:0] HIGH_WINDOW_PAGE = 8'h11;

  typedef struct packed {
    logic                    enable;
    logic [CHAN_FIELD_W-1:0] chan;
  } mapEntry_t;

  // Strobes from the address control to the datapath.
  typedef struct packed {
    logic                  wrStb;
    logic                  rdReq;
    logic                  rdHit;
    logic [LINE_IDX_W-1:0] wrIdx;
    logic [LINE_IDX_W-1:0] rdIdx;
    mapEntry_t             wrEntry;
  } ctl_t;

endpackage

// File: rtl/rr_ctrl.sv
`timescale 1ns/1ps
module rr_ctrl
  import rr_pkg::*;
#(
  parameter int NUM_LINES = 96,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctl_t              ctl
);

  localparam int PAGE_W = ADDR_W - 8;

  logic                  wrHit, rdHit;
  logic [LINE_IDX_W-1:0] wrIdx, rdIdx;

  // Address to line index; hit only for an aligned address in a window
  // whose line exists.
  function automatic logic decodeHit(input logic [ADDR_W-1:0] a,
                                     output logic [LINE_IDX_W-1:0] idx);
    logic [PAGE_W-1:0] page;
    logic lowWin, highWin, aligned;
    page    = a[ADDR_W-1:8];
    lowWin  = (page == PAGE_W'(LOW_WINDOW_PAGE));
    highWin = (page == PAGE_W'(HIGH_WINDOW_PAGE));
    aligned = (a[1:0] == 2'b00);
    idx     = {highWin, a[7:2]};
    return aligned && (lowWin || highWin) && (int'(idx) < NUM_LINES);
  endfunction

  always_comb begin
    wrHit = decodeHit(wrAddr, wrIdx);
    rdHit = decodeHit(rdAddr, rdIdx);
  end

  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[DATA_W-1:ENABLE_BIT+1],
                          wrData[ENABLE_BIT-1:CHAN_FIELD_W]};

  always_comb begin
    ctl                = '0;
    ctl.wrStb          = wrEn && wrHit;
    ctl.rdReq          = rdEn;
    ctl.rdHit          = rdEn && rdHit;
    ctl.wrIdx          = wrIdx;
    ctl.rdIdx          = rdIdx;
    ctl.wrEntry.enable = wrData[ENABLE_BIT];
    ctl.wrEntry.chan   = wrData[CHAN_FIELD_W-1:0];
  end

endmodule

// File: rtl/rr_table.sv
`timescale 1ns/1ps
module rr_table
  import rr_pkg::*;
#(
  parameter int NUM_LINES = 96,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctl_t                        ctl,
  output mapEntry_t [NUM_LINES-1:0]   mapOut,
  output logic [DATA_W-1:0]           rdData
);

  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  mapEntry_t [NUM_LINES-1:0] mapQ;
  mapEntry_t                 rdEntry;

  // One register per line; only the addressed one loads.
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)
        mapQ[n] <= '0;
      else if (ctl.wrStb && (ctl.wrIdx == LINE_IDX_W'(n)))
        mapQ[n] <= ctl.wrEntry;
    end
  end

  assign rdEntry = mapQ[ctl.rdIdx[LW-1:0]];

  logic unusedRdIdx;
  assign unusedRdIdx = ^ctl.rdIdx;

  // Registered read: hit returns the entry, miss returns zero.
  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (ctl.rdReq)
      rdData <= ctl.rdHit
              ? DATA_W'({rdEntry.enable, 2'b00, rdEntry.chan})
              : '0;
  end

  assign mapOut = mapQ;

endmodule

// File: rtl/rr_route.sv
`timescale 1ns/1ps
module rr_route
  import rr_pkg::*;
#(
  parameter int NUM_LINES = 96,
  parameter int NUM_CHANS = 32
) (
  input  mapEntry_t [NUM_LINES-1:0] mapIn,
  input  logic [NUM_LINES-1:0]      perReq,
  input  logic [NUM_CHANS-1:0]      chanAck,
  output logic [NUM_CHANS-1:0]      chanReq,
  output logic [NUM_LINES-1:0]      perAck
);

  logic [MAX_CHANS-1:0] ackPad;
  assign ackPad = MAX_CHANS'(chanAck);

  // Request fan-in: each channel ORs the lines that name it.
  for (genvar c = 0; c < NUM_CHANS; c++) begin : g_chan
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int n = 0; n < NUM_LINES; n++)
        acc = acc | (perReq[n] & mapIn[n].enable &
                     (mapIn[n].chan == CHAN_FIELD_W'(c)));
    end
    assign chanReq[c] = acc;
  end

  // Acknowledge fan-out: each line follows its mapped channel.
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    assign perAck[n] = mapIn[n].enable & ackPad[mapIn[n].chan];
  end

endmodule

// File: rtl/rr_datapath.sv
`timescale 1ns/1ps
module rr_datapath
  import rr_pkg::*;
#(
  parameter int NUM_LINES = 96,
  parameter int NUM_CHANS = 32,
  parameter int DATA_W    = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctl_t                  ctl,
  output logic [DATA_W-1:0]     rdData,
  input  logic [NUM_LINES-1:0]  perReq,
  output logic [NUM_CHANS-1:0]  chanReq,
  input  logic [NUM_CHANS-1:0]  chanAck,
  output logic [NUM_LINES-1:0]  perAck
);

  mapEntry_t [NUM_LINES-1:0] mapBus;

  rr_table #(
    .NUM_LINES(NUM_LINES),
    .DATA_W   (DATA_W)
  ) u_table (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .mapOut(mapBus),
    .rdData(rdData)
  );

  rr_route #(
    .NUM_LINES(NUM_LINES),
    .NUM_CHANS(NUM_CHANS)
  ) u_route (
    .mapIn  (mapBus),
    .perReq (perReq),
    .chanAck(chanAck),
    .chanReq(chanReq),
    .perAck (perAck)
  );

endmodule

// File: rtl/req_router.sv
`timescale 1ns/1ps
module req_router
  import rr_pkg::*;
#(
  parameter int NUM_LINES = 96,
  parameter int NUM_CHANS = 32,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_LINES-1:0] perReq,
  output logic [NUM_CHANS-1:0] chanReq,
  input  logic [NUM_CHANS-1:0] chanAck,
  output logic [NUM_LINES-1:0] perAck
);

  ctl_t ctl;

  rr_ctrl #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_ctrl (
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdEn  (rdEn),
    .rdAddr(rdAddr),
    .ctl   (ctl)
  );

  rr_datapath #(
    .NUM_LINES(NUM_LINES),
    .NUM_CHANS(NUM_CHANS),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .rdData (rdData),
    .perReq (perReq),
    .chanReq(chanReq),
    .chanAck(chanAck),
    .perAck (perAck)
  );

endmodule

// File: rtl/req_router_chk.sv
`timescale 1ns/1ps
module req_router_chk #(
  parameter int NUM_LINES = 96,
  parameter int NUM_CHANS = 32,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    wrAddr,
  input logic [DATA_W-1:0]    wrData,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    rdAddr,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_LINES-1:0] perReq,
  input logic [NUM_CHANS-1:0] chanReq,
  input logic [NUM_CHANS-1:0] chanAck,
  input logic [NUM_LINES-1:0] perAck
);

  // R1: the cycle after a reset edge everything reads quiet.
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (rdData == '0 && chanReq == '0 && perAck == '0));

  // R2: read data changes only when a read is issued.
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R2: bits outside the enable flag and channel field stay zero.
  p_rd_fields_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> (rdData[DATA_W-1:8] == '0 && rdData[6:5] == 2'b00));

  // R4: no channel request without some line requesting.
  p_req_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|chanReq) |-> (|perReq));

  // R7: no line acknowledge without some channel acknowledging.
  p_ack_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|perAck) |-> (|chanAck));

  // R6: clearing the enable flag of line 0 silences its acknowledge.
  p_clear_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(16'h0100) && !wrData[7]) |=> !perAck[0]);

endmodule

bind req_router req_router_chk #(
  .NUM_LINES(NUM_LINES),
  .NUM_CHANS(NUM_CHANS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (.*);

// File: tb/req_router_test.sv
`timescale 1ns/1ps
module req_router_test;

  localparam int NL = 96;
  localparam int NC = 32;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrEn, rdEn;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [DW-1:0] wrData;
  logic [DW-1:0] rdData;
  logic [NL-1:0] perReq, perAck;
  logic [NC-1:0] chanReq, chanAck;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic [7:0]    model [NL];
  logic [DW-1:0] rdPrev;

  always #10 clk = ~clk;

  req_router #(.NUM_LINES(NL), .NUM_CHANS(NC), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .perReq(perReq),
    .chanReq(chanReq), .chanAck(chanAck), .perAck(perAck));

  function automatic logic [AW-1:0] addrOf(input int n);
    return (n < 64) ? AW'(16'h0100 + 4 * n) : AW'(16'h1100 + 4 * (n % 64));
  endfunction

  function automatic bit decodeAddr(input logic [AW-1:0] a, output int idx);
    idx = 0;
    if (a[1:0] != 2'b00) return 0;
    if (a[15:8] == 8'h01) idx = int'(a[7:2]);
    else if (a[15:8] == 8'h11) idx = 64 + int'(a[7:2]);
    else return 0;
    return idx < NL;
  endfunction

  function automatic logic [NC-1:0] expReq(input logic [NL-1:0] pr);
    logic [NC-1:0] r = '0;
    for (int n = 0; n < NL; n++)
      if (pr[n] && model[n][7]) r[model[n][4:0]] = 1'b1;
    return r;
  endfunction

  function automatic logic [NL-1:0] expAck(input logic [NC-1:0] ca);
    logic [NL-1:0] r = '0;
    for (int n = 0; n < NL; n++)
      r[n] = model[n][7] && ca[model[n][4:0]];
    return r;
  endfunction

  function automatic logic [DW-1:0] expRead(input logic [AW-1:0] a);
    int idx;
    if (!decodeAddr(a, idx)) return '0;
    return DW'(model[idx]);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle (called just after a rising edge), check routing before
  // the edge and read data after it.
  task automatic doCycle(input bit we, input logic [AW-1:0] wa,
                         input logic [DW-1:0] wd, input bit re,
                         input logic [AW-1:0] ra, input logic [NL-1:0] pr,
                         input logic [NC-1:0] ca);
    logic [DW-1:0] rdExp;
    int idx;
    wrEn = we; wrAddr = wa; wrData = wd;
    rdEn = re; rdAddr = ra; perReq = pr; chanAck = ca;
    #5;
    chk(chanReq == expReq(pr), "R4 channel request", 128'(chanReq), 128'(expReq(pr)));
    chk(perAck == expAck(ca), "R7 line acknowledge", 128'(perAck), 128'(expAck(ca)));
    rdExp = re ? expRead(ra) : rdPrev;
    @(posedge clk); #1;
    if (we && decodeAddr(wa, idx)) model[idx] = {wd[7], 2'b00, wd[4:0]};
    chk(rdData == rdExp, "R2 read data", 128'(rdData), 128'(rdExp));
    rdPrev = rdExp;
    wrEn = 0; rdEn = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    doCycle(1, a, d, 0, '0, '0, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    doCycle(0, '0, '0, 1, a, '0, '0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < NL; n++) model[n] = '0;
    rdPrev = '0;
    rstN = 0; wrEn = 0; rdEn = 0; wrAddr = '0; rdAddr = '0; wrData = '0;
    perReq = '1; chanAck = '1;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #5;
    // R1: reset state with every input line high
    chk(chanReq == '0, "R1 reset chanReq", 128'(chanReq), 128'(0));
    chk(perAck == '0, "R1 reset perAck", 128'(perAck), 128'(0));
    chk(rdData == '0, "R1 reset rdData", 128'(rdData), 128'(0));
    @(posedge clk); #1;

    // R2: only enable and channel fields are kept
    wr(16'h0100, 32'hFFFF_FF83);
    rd(16'h0100);
    chk(rdData == 32'h83, "R2 field readback", 128'(rdData), 128'h83);

    // R3: high window entry and its low window alias
    wr(addrOf(70), 32'h0000_0091);
    rd(16'h1118);
    chk(rdData == 32'h91, "R3 high window line 70", 128'(rdData), 128'h91);
    rd(16'h0118);
    chk(rdData == 32'h0, "R3 low window line 6", 128'(rdData), 128'h0);
    perReq = '0; perReq[70] = 1'b1; #5;
    chk(chanReq == (NC'(1) << 17), "R3 line 70 routes to 17", 128'(chanReq), 128'(NC'(1) << 17));
    @(posedge clk); #1;

    // R5: disabled entry with a non-zero channel field
    wr(16'h0104, 32'h0000_0005);
    perReq = '0; perReq[1] = 1'b1; chanAck = '1; #5;
    chk(chanReq == '0, "R5 disabled entry request", 128'(chanReq), 128'(0));
    chk(perAck[1] == 1'b0, "R5 disabled entry ack", 128'(perAck[1]), 128'(0));
    @(posedge clk); #1;

    // R6: clear line 0 (channel 3)
    perReq = '0; perReq[0] = 1'b1; chanAck = '0; #5;
    chk(chanReq == (NC'(1) << 3), "R6 before clear", 128'(chanReq), 128'(NC'(1) << 3));
    @(posedge clk); #1;
    wr(16'h0100, 32'h0);
    perReq = '0; perReq[0] = 1'b1; chanAck = '1; #5;
    chk(chanReq == '0, "R6 cleared request", 128'(chanReq), 128'(0));
    chk(perAck[0] == 1'b0, "R6 cleared ack", 128'(perAck[0]), 128'(0));
    @(posedge clk); #1;

    // R8: accesses that hit nothing
    wr(16'h0101, 32'hFF);
    wr(16'h11A0, 32'hFF);
    wr(16'h0200, 32'hFF);
    wr(16'h0000, 32'hFF);
    rd(16'h0101);
    chk(rdData == '0, "R8 misaligned read", 128'(rdData), 128'(0));
    rd(16'h11A0);
    chk(rdData == '0, "R8 line beyond count", 128'(rdData), 128'(0));
    chk(model[64] == 8'h0 && model[0] == 8'h0, "R8 model untouched", 128'(model[64]), 128'(0));
    for (int n = 0; n < NL; n++) rd(addrOf(n));
    rd(16'h0104);
    chk(rdData == 32'h05, "R8 table intact after stray writes", 128'(rdData), 128'h05);

    // R9: write and read of line 2 in one cycle
    wr(16'h0108, 32'h84);
    doCycle(1, 16'h0108, 32'h89, 1, 16'h0108, '0, '0);
    chk(rdData == 32'h84, "R9 same-cycle read returns old", 128'(rdData), 128'h84);
    rd(16'h0108);
    chk(rdData == 32'h89, "R9 new value after edge", 128'(rdData), 128'h89);
    // R9: reroute line 2 from 9 to 12 while it requests
    perReq = '0; perReq[2] = 1'b1;
    wrEn = 1; wrAddr = 16'h0108; wrData = 32'h8C; #5;
    chk(chanReq == (NC'(1) << 9), "R9 old route in write cycle", 128'(chanReq), 128'(NC'(1) << 9));
    @(posedge clk); #1;
    model[2] = 8'h8C; wrEn = 0; #5;
    chk(chanReq == (NC'(1) << 12), "R9 new route after edge", 128'(chanReq), 128'(NC'(1) << 12));
    @(posedge clk); #1;

    // Random traffic
    for (int i = 0; i < 1500; i++) begin
      logic [AW-1:0] wa, ra;
      int ln;
      ln = int'($urandom_range(NL - 1));
      wa = ($urandom_range(9) == 0) ? AW'($urandom) : addrOf(ln);
      ra = ($urandom_range(9) == 0) ? AW'($urandom) : addrOf(int'($urandom_range(NL - 1)));
      if ($urandom_range(3) == 0) ra = wa;
      doCycle(($urandom_range(2) == 0), wa, $urandom, $urandom_range(1) == 1, ra,
              NL'({$urandom, $urandom, $urandom}), NC'($urandom));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule